// File: doc/BRIEF.md
# Gated Serial Link Clock Generator

This block makes the serial link clock from the module system clock. A direction input chooses between two roles. When the block is the clock source, it divides the system clock by a 3-bit setting and drives the result, and it asserts the pad output-enable. When it is not the source, it passes an externally supplied clock through and releases the pad.

With power saving switched on and the block acting as the clock source, the divided clock parks low whenever no serial traffic is pending. It restarts as soon as traffic appears. The traffic-pending input is asynchronous and passes through a two-flop synchroniser. Every start and stop of the clock falls on a low-phase boundary, so no shortened pulse ever reaches the link.

Top module: `serclk_gen`

## Requirements
- R1: While driving, with divider value D (0 to 7) held steady, each high phase and each low phase of `link_clk` lasts exactly D+1 system clock cycles, so one period is 2*(D+1) cycles.
- R2: With `drive_en` = 0, `link_clk` equals `ext_clk` and `clk_oe` is 0. With `drive_en` = 1, `clk_oe` is 1.
- R3: With `pm_en` = 0, the driven clock runs continuously whatever the value of `traffic_req`.
- R4: With `pm_en` = 1 and `traffic_req` low, the driven clock stops and is held low.
- R5: A stop request never shortens a high phase. A high phase already under way completes its full D+1 cycles before the clock parks low.
- R6: From the parked state, when `traffic_req` is first sampled high at rising edge n of `clk`, `link_clk` goes high at edge n+2.
- R7: A change of `div_sel` reloads the phase counter at the edge where the change is seen. The current level then holds for the new D+1 cycles, and this reload takes precedence over a restart that falls due in the same cycle.
- R8: While `rst_n` is low and `drive_en` is 1, `link_clk` is low.
- R9: When `drive_en` rises, the internal clock starts from its low level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 3 | Divider value D; half period is D+1 cycles |
| drive_en | input | 1 | 1: block drives the link clock; 0: external clock is used |
| pm_en | input | 1 | 1: stop the driven clock while no traffic is pending |
| traffic_req | input | 1 | Asynchronous traffic-pending indication |
| ext_clk | input | 1 | Externally supplied link clock |
| link_clk | output | 1 | Selected link clock |
| clk_oe | output | 1 | Output-enable for the clock pad |

## Verification
Two events can fall on the same system clock edge: a divider reload, and the restart of a parked clock once synchronised traffic arrives. The bench provokes this from the parked state. It changes `div_sel` from 3 to 2 and raises `traffic_req` at the same falling edge. Because the reload wins, the clock must stay low at the samples after the first three rising edges and go high only after the fourth. A design that lets the restart win would rise one cycle early.

// File: rtl/serclk_pkg.sv
// Package: shared types for the serial clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package serclk_pkg;

    // Level of the internally generated divided clock
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/serclk_sync.sv
// Module: serclk_sync
// Brings an asynchronous level into the clk domain through a chain of
// STAGES flops. Assumes STAGES >= 2 and an input that stays steady for
// longer than one clk period.
module serclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the chain; clears on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/serclk_core.sv
// Module: serclk_core
// Down-counter divider. It toggles its output every DIV+1 cycles. While
// want_run is low it parks after a full low phase and resumes from the
// parked state on the next edge where want_run is high. A divider change
// reloads the counter at once.
// Assumes: run_en low forces the output low and keeps the divider tracked.
module serclk_core
    import serclk_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             run_en,
    input  logic             want_run,
    output logic             clk_int
);

    phase_e           phase_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;

    // Phase counter, divider tracking and start/stop at low boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
            div_q   <= '0;
        end else if (!run_en) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
            div_q   <= div_sel;
        end else if (div_sel != div_q) begin
            div_q   <= div_sel;
            cnt_q   <= div_sel;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end else if (phase_q == PH_HIGH) begin
            phase_q <= PH_LOW;
            cnt_q   <= div_q;
        end else if (want_run) begin
            phase_q <= PH_HIGH;
            cnt_q   <= div_q;
        end
    end

    assign clk_int = (phase_q == PH_HIGH);

endmodule

// File: rtl/serclk_pad_mux.sv
// Module: serclk_pad_mux
// Picks the link clock source and drives the pad output-enable.
// Assumes: the switch of drive_en happens while both clocks are low.
module serclk_pad_mux (
    input  logic drive_en,
    input  logic clk_int,
    input  logic ext_clk,
    output logic link_clk,
    output logic clk_oe
);

    // Source selection for the link clock
    always_comb begin
        link_clk = drive_en ? clk_int : ext_clk;
        clk_oe   = drive_en;
    end

endmodule

// File: rtl/serclk_gen.sv
// Module: serclk_gen (top)
// Serial link clock generator. It divides clk when driving, passes ext_clk
// otherwise, and parks the driven clock low while power saving is on and
// no traffic is pending.
// Assumes: traffic_req is asynchronous; div_sel, drive_en and pm_en are
// synchronous to clk.
module serclk_gen #(
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             drive_en,
    input  logic             pm_en,
    input  logic             traffic_req,
    input  logic             ext_clk,
    output logic             link_clk,
    output logic             clk_oe
);

    logic traffic_s;
    logic want_run;
    logic clk_int;

    serclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (traffic_req),
        .q_sync  (traffic_s)
    );

    // Run request: always when power saving is off, else only with traffic
    always_comb begin
        want_run = !pm_en || traffic_s;
    end

    serclk_core #(.DIV_W(DIV_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .run_en   (drive_en),
        .want_run (want_run),
        .clk_int  (clk_int)
    );

    serclk_pad_mux u_mux (
        .drive_en (drive_en),
        .clk_int  (clk_int),
        .ext_clk  (ext_clk),
        .link_clk (link_clk),
        .clk_oe   (clk_oe)
    );

endmodule

// File: rtl/serclk_gen_chk.sv
// Module: serclk_gen_chk
// Property checker bound to serclk_gen. It tracks the lengths of the high
// and low runs of link_clk with its own counters.
// Assumes: two synchroniser stages (the default).
module serclk_gen_chk #(
    parameter int DIV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_sel,
    input logic             drive_en,
    input logic             pm_en,
    input logic             traffic_req,
    input logic             link_clk
);

    localparam int LEN_W = DIV_W + 2;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic [LEN_W-1:0] hi_len;
    logic [LEN_W-1:0] lo_len;
    logic             hi_dirty;
    logic             lo_dirty;
    logic [DIV_W-1:0] div_prev;

    // Run-length bookkeeping; a run is marked dirty if it cannot be judged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len   <= '0;
            lo_len   <= '0;
            hi_dirty <= 1'b1;
            lo_dirty <= 1'b1;
            div_prev <= '0;
        end else begin
            div_prev <= div_sel;
            if (!drive_en) begin
                hi_len   <= '0;
                lo_len   <= '0;
                hi_dirty <= 1'b1;
                lo_dirty <= 1'b1;
            end else if (link_clk) begin
                lo_len   <= '0;
                lo_dirty <= 1'b0;
                if (hi_len != LEN_MAX) hi_len <= hi_len + 1'b1;
                if (div_sel != div_prev) hi_dirty <= 1'b1;
            end else begin
                hi_len   <= '0;
                hi_dirty <= 1'b0;
                if (lo_len != LEN_MAX) lo_len <= lo_len + 1'b1;
            end
        end
    end

    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en) && $fell(link_clk) && !hi_dirty)
        |-> (hi_len == {2'b00, $past(div_sel)} + 1'b1)); // R5

    AST_LOW_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en) && $rose(link_clk) && !lo_dirty)
        |-> (lo_len >= {2'b00, $past(div_sel)} + 1'b1)); // R1

    AST_IDLE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en) && $past(pm_en) && !$past(traffic_req, 3))
        |-> !$rose(link_clk)); // R4

    AST_START_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> !link_clk); // R9

endmodule

bind serclk_gen serclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_sel     (div_sel),
    .drive_en    (drive_en),
    .pm_en       (pm_en),
    .traffic_req (traffic_req),
    .link_clk    (link_clk)
);

// File: tb/serclk_gen_bench.sv
// Bench for serclk_gen: a vector table of steady-state settings, then
// directed tests for reset, stop, restart, reload and source selection.
module serclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] div_sel;
    logic       drive_en;
    logic       pm_en;
    logic       traffic_req;
    logic       ext_clk;
    logic       link_clk;
    logic       clk_oe;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    serclk_gen u_serclk_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_sel     (div_sel),
        .drive_en    (drive_en),
        .pm_en       (pm_en),
        .traffic_req (traffic_req),
        .ext_clk     (ext_clk),
        .link_clk    (link_clk),
        .clk_oe      (clk_oe)
    );

    // Entry: div[8:6], pm[5], traffic[4], expected half period[3:0] (0 = parked)
    localparam logic [8:0] VEC [7] = '{
        {3'd0, 1'b0, 1'b0, 4'd1},
        {3'd1, 1'b0, 1'b1, 4'd2},
        {3'd3, 1'b0, 1'b0, 4'd4},
        {3'd7, 1'b0, 1'b0, 4'd8},
        {3'd2, 1'b1, 1'b1, 4'd3},
        {3'd2, 1'b1, 1'b0, 4'd0},
        {3'd5, 1'b1, 1'b1, 4'd6}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(output bit found);
        logic prev;
        found = 1'b0;
        prev = link_clk;
        for (int g = 0; g < 80; g++) begin
            @(negedge clk);
            if (!prev && link_clk) begin
                found = 1'b1;
                break;
            end
            prev = link_clk;
        end
    endtask

    // Called right after a rising edge was seen: counts high, then low samples
    task automatic count_phases(output int hi, output int lo);
        hi = 1;
        lo = 0;
        forever begin
            @(negedge clk);
            if (!link_clk || hi > 40) break;
            hi++;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (link_clk || lo > 40) break;
            lo++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #500000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        bit found;
        int hi, lo, bad;

        rst_n = 1'b0; div_sel = 3'd0; drive_en = 1'b1; pm_en = 1'b0;
        traffic_req = 1'b0; ext_clk = 1'b0;
        idle(4);
        check(link_clk == 1'b0, "R8 low in reset", link_clk, 0);
        check(clk_oe == 1'b1, "R2 oe while driving", clk_oe, 1);
        rst_n = 1'b1;

        // Table walk: steady-state phase lengths or parked level
        for (int v = 0; v < 7; v++) begin
            div_sel = VEC[v][8:6];
            pm_en = VEC[v][5];
            traffic_req = VEC[v][4];
            idle(40);
            if (VEC[v][3:0] != 4'd0) begin
                wait_rise(found);
                check(found, "R1/R3 clock running", found, 1);
                count_phases(hi, lo);
                check(hi == VEC[v][3:0], "R1 high phase", hi, VEC[v][3:0]);
                check(lo == VEC[v][3:0], "R1 low phase", lo, VEC[v][3:0]);
            end else begin
                bad = 0;
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    if (link_clk) bad++;
                end
                check(bad == 0, "R4 parked low", bad, 0);
            end
        end

        // R5: stop requested at start of a high phase keeps the full phase
        div_sel = 3'd3; pm_en = 1'b1; traffic_req = 1'b1;
        idle(30);
        wait_rise(found);
        traffic_req = 1'b0;
        count_phases(hi, lo);
        check(hi == 4, "R5 high phase not cut", hi, 4);
        check(lo > 40, "R5 parked after stop", lo, 41);

        // R6: restart latency from parked state
        traffic_req = 1'b1;
        @(negedge clk);
        check(link_clk == 1'b0, "R6 low after edge n", link_clk, 0);
        @(negedge clk);
        check(link_clk == 1'b0, "R6 low after edge n+1", link_clk, 0);
        @(negedge clk);
        check(link_clk == 1'b1, "R6 high after edge n+2", link_clk, 1);

        // R7: divider reload coinciding with restart; reload wins
        traffic_req = 1'b0;
        idle(40);
        div_sel = 3'd2; traffic_req = 1'b1;
        idle(3);
        check(link_clk == 1'b0, "R7 reload delays restart", link_clk, 0);
        @(negedge clk);
        check(link_clk == 1'b1, "R7 rise after reload", link_clk, 1);

        // R7: divider change mid-run gives new period at once
        pm_en = 1'b0; div_sel = 3'd7;
        idle(40);
        wait_rise(found);
        idle(2);
        div_sel = 3'd1;
        wait_rise(found);
        count_phases(hi, lo);
        check(hi == 2 && lo == 2, "R7 new divider period", hi * 10 + lo, 22);

        // R2: external clock passthrough
        drive_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ext_clk = i[0];
            #1;
            check(link_clk == ext_clk && clk_oe == 1'b0, "R2 external source",
                  {link_clk, clk_oe}, {ext_clk, 1'b0});
        end

        // R9: switching to driving starts from low
        ext_clk = 1'b1;
        @(negedge clk);
        drive_en = 1'b1;
        #1;
        check(link_clk == 1'b0, "R9 start low", link_clk, 0);
        @(negedge clk);
        check(link_clk == 1'b1, "R3 runs after start", link_clk, 1);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule